// File: doc/BRIEF.md
# Hot-swap slot power sequencer

This block runs the live-insertion sequence for one card slot. It learns that a card is present in one of two ways: from the slot's card-sense bits, or from an operator request level driven by a front panel or console command. It then brings the slot up in a fixed order. First it keeps the slot reset low and the data-bus isolation switches open. Next it raises the enable line of an external power controller. It waits for that controller to report power-good, and then for a reset time-out. Only after that does it close the bus switches and release the slot reset.

The external controller latches a current fault and reports it on an active-low line. That fault clears only when the enable line is taken low and raised again. When the sequencer sees a fault, it shuts the slot down at once and holds the enable line low for a minimum pulse width. It then restarts the sequence if the slot is still occupied. The sequencer also shuts the slot down at once when the card is removed. If power-good does not arrive within a bounded wait, the sequencer treats that as a fault.

The analog side is not part of this block: supply ramping, current sensing and the switches themselves. It sees that side only through the digital lines below. All timing values are counted in clock cycles.

Top module: `slot_pwr_seq`

## Requirements
- R1: During and right after reset, slot_rst_n_o=0, bus_en_o=0, pwr_en_o=0 and status_o=0 (idle).
- R2: The slot counts as occupied when card_sense_i is not all ones (an empty slot pulls every bit high) or when op_insert_i=1. Each input passes through two synchroniser flops. From idle, pwr_en_o goes high on the third rising edge after occupancy appears at the pins.
- R3: When pwr_en_o rises, slot_rst_n_o is 0 and bus_en_o is 0.
- R4: While powering (status 1), the sequencer waits for synchronised pgood_i=1. If power-good has not arrived after PG_MAX_CYC cycles in that state, it enters the fault state (status 4).
- R5: After power-good is seen, the sequencer stays in the waiting state (status 2) for RST_TO_CYC cycles, with the bus isolated and reset low.
- R6: When the time-out ends, bus_en_o goes high for exactly one cycle while slot_rst_n_o stays 0. Reset is released on the next cycle, and status_o becomes 3 (active).
- R7: A synchronised fault_n_i=0 sends the sequencer to the fault state, with all three slot outputs driven to their off values on the following cycle. This applies while waiting, connecting or active. While powering, it applies only once FLT_BLANK_CYC cycles have passed in that state; a fault seen earlier than that is ignored.
- R8: In the fault state, pwr_en_o stays low for PULSE_MIN_CYC cycles. The sequencer then returns to idle and, if the slot is still occupied, raises pwr_en_o again one cycle later.
- R9: If the slot stops being occupied in any powered state, the sequencer goes to idle and all slot outputs turn off three rising edges after the change at the pins.
- R10: status_o encodes 0 idle, 1 powering, 2 waiting (including the single connect cycle), 3 active, 4 fault; no other value appears.
- R11: slot_rst_n_o is high only while bus_en_o and pwr_en_o are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_sense_i | input | PRES_W | Asynchronous card-sense bits, all ones when the slot is empty |
| op_insert_i | input | 1 | Asynchronous operator level declaring a card inserted |
| pgood_i | input | 1 | Asynchronous power-good from the power controller |
| fault_n_i | input | 1 | Asynchronous latched fault from the power controller, active low |
| slot_rst_n_o | output | 1 | Slot reset, active low |
| bus_en_o | output | 1 | Bus isolation switch enable, 1 = connected |
| pwr_en_o | output | 1 | Power controller enable |
| status_o | output | 3 | Sequencer status code |

## Verification
The assertions check the ordering rules on every cycle. When power comes on, the bus is isolated and reset is held. Reset is released only with the bus connected and power on, and the bus is enabled in the cycle before the release. Every fault cycle has the slot fully off, the status code is always legal, and the enable pulse that follows a fault is never shorter than its minimum. Some behaviours can only be shown by the bench scenarios against its cycle model: the exact latency through the synchronisers, the length of the reset time-out, the power-good timeout, the fault blanking window early in power-up, and the restart or idle outcome after a fault pulse.

// File: rtl/slot_pwr_pkg.sv
`timescale 1ns/1ps
// Shared types for the slot power sequencer: internal state encoding and
// the mapping onto the externally visible status code.
package slot_pwr_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_POWER   = 3'd1,
        SEQ_WAIT    = 3'd2,
        SEQ_CONNECT = 3'd3,
        SEQ_ACTIVE  = 3'd4,
        SEQ_FAULT   = 3'd5
    } seq_state_t;

    localparam logic [2:0] STAT_IDLE   = 3'd0;
    localparam logic [2:0] STAT_POWER  = 3'd1;
    localparam logic [2:0] STAT_WAIT   = 3'd2;
    localparam logic [2:0] STAT_ACTIVE = 3'd3;
    localparam logic [2:0] STAT_FAULT  = 3'd4;

    // Map an internal state onto the five-value status code.
    function automatic logic [2:0] state_to_status(input seq_state_t st);
        case (st)
            SEQ_IDLE:    return STAT_IDLE;
            SEQ_POWER:   return STAT_POWER;
            SEQ_WAIT,
            SEQ_CONNECT: return STAT_WAIT;
            SEQ_ACTIVE:  return STAT_ACTIVE;
            default:     return STAT_FAULT;
        endcase
    endfunction

endpackage

// File: rtl/slot_sync.sv
`timescale 1ns/1ps
// Multi-bit synchroniser chain for independent asynchronous level inputs.
// Each bit is retimed through STAGES flops on its own; no bus coherency is
// assumed between bits. The reset value is chosen per bit so that each
// input starts at its inactive level.
module slot_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage: capture the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d_i;
            end
        end else begin : g_next
            // Later stages: let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/slot_timer.sv
`timescale 1ns/1ps
// Saturating cycle counter used for all sequencer intervals.
// Assumes the controller pulses clr_i on every state change, so the count
// reads the number of cycles spent in the current state.
module slot_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Count up, restart on clear, hold at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)  cnt_o <= '0;
        else if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
    end

endmodule

// File: rtl/slot_fsm.sv
`timescale 1ns/1ps
// Sequencing state machine. Enforces: isolate, power, power-good, time-out,
// connect, release. Handles fault shutdown with a minimum enable-low pulse,
// and card removal. Assumes all inputs are already synchronised and cnt_i
// counts cycles since the last state change.
module slot_fsm
    import slot_pwr_pkg::*;
#(
    parameter int PG_MAX_CYC    = 64,
    parameter int RST_TO_CYC    = 20,
    parameter int PULSE_MIN_CYC = 8,
    parameter int FLT_BLANK_CYC = 4,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             occupied_i,
    input  logic             pgood_i,
    input  logic             fault_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr_o,
    output logic             slot_rst_n_o,
    output logic             bus_en_o,
    output logic             pwr_en_o,
    output logic [2:0]       status_o
);

    localparam logic [CNT_W-1:0] PG_LAST    = CNT_W'(PG_MAX_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LAST    = CNT_W'(RST_TO_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_MIN_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK_END  = CNT_W'(FLT_BLANK_CYC);

    seq_state_t state_q, state_d;
    logic       fault_live;

    // Faults during early power-up are blanked while the latch settles.
    assign fault_live = fault_i && ((state_q != SEQ_POWER) || (cnt_i >= BLANK_END));

    // Next-state selection; removal beats fault, fault beats progress.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: begin
                if (occupied_i) state_d = SEQ_POWER;
            end
            SEQ_POWER: begin
                if (!occupied_i)          state_d = SEQ_IDLE;
                else if (fault_live)      state_d = SEQ_FAULT;
                else if (pgood_i)         state_d = SEQ_WAIT;
                else if (cnt_i >= PG_LAST) state_d = SEQ_FAULT;
            end
            SEQ_WAIT: begin
                if (!occupied_i)          state_d = SEQ_IDLE;
                else if (fault_live)      state_d = SEQ_FAULT;
                else if (cnt_i >= TO_LAST) state_d = SEQ_CONNECT;
            end
            SEQ_CONNECT: begin
                if (!occupied_i)     state_d = SEQ_IDLE;
                else if (fault_live) state_d = SEQ_FAULT;
                else                 state_d = SEQ_ACTIVE;
            end
            SEQ_ACTIVE: begin
                if (!occupied_i)     state_d = SEQ_IDLE;
                else if (fault_live) state_d = SEQ_FAULT;
            end
            SEQ_FAULT: begin
                if (cnt_i >= PULSE_LAST) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    assign cnt_clr_o = (state_d != state_q);

    // Slot output decode from the registered state only.
    always_comb begin
        pwr_en_o     = (state_q == SEQ_POWER) || (state_q == SEQ_WAIT) ||
                       (state_q == SEQ_CONNECT) || (state_q == SEQ_ACTIVE);
        bus_en_o     = (state_q == SEQ_CONNECT) || (state_q == SEQ_ACTIVE);
        slot_rst_n_o = (state_q == SEQ_ACTIVE);
        status_o     = state_to_status(state_q);
    end

endmodule

// File: rtl/slot_pwr_seq.sv
`timescale 1ns/1ps
// Top of the hot-swap slot power sequencer. Synchronises the asynchronous
// slot inputs, derives slot occupancy, and drives reset, bus switch and
// power enable through the sequencing state machine. Assumes the external
// power controller latches faults until its enable is cycled.
module slot_pwr_seq #(
    parameter int PRES_W        = 2,
    parameter int PG_MAX_CYC    = 64,
    parameter int RST_TO_CYC    = 20,
    parameter int PULSE_MIN_CYC = 8,
    parameter int FLT_BLANK_CYC = 4,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRES_W-1:0] card_sense_i,
    input  logic              op_insert_i,
    input  logic              pgood_i,
    input  logic              fault_n_i,
    output logic              slot_rst_n_o,
    output logic              bus_en_o,
    output logic              pwr_en_o,
    output logic [2:0]        status_o
);

    localparam int MAX_AB  = (PG_MAX_CYC > RST_TO_CYC) ? PG_MAX_CYC : RST_TO_CYC;
    localparam int MAX_CD  = (PULSE_MIN_CYC > FLT_BLANK_CYC) ? PULSE_MIN_CYC : FLT_BLANK_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;
    localparam int SYN_W   = PRES_W + 3;
    localparam logic [SYN_W-1:0] SYN_RST = {1'b1, 1'b0, 1'b0, {PRES_W{1'b1}}};

    logic [SYN_W-1:0]  syn_q;
    logic [PRES_W-1:0] sense_s;
    logic              op_s, pg_s, fault_n_s, occupied;
    logic              cnt_clr;
    logic [CNT_W-1:0]  cnt;

    slot_sync #(
        .W       (SYN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({fault_n_i, pgood_i, op_insert_i, card_sense_i}),
        .q_o   (syn_q)
    );

    assign {fault_n_s, pg_s, op_s, sense_s} = syn_q;

    // An empty slot pulls every sense bit high; an operator level also counts.
    assign occupied = (~&sense_s) | op_s;

    slot_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    slot_fsm #(
        .PG_MAX_CYC    (PG_MAX_CYC),
        .RST_TO_CYC    (RST_TO_CYC),
        .PULSE_MIN_CYC (PULSE_MIN_CYC),
        .FLT_BLANK_CYC (FLT_BLANK_CYC),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .occupied_i   (occupied),
        .pgood_i      (pg_s),
        .fault_i      (~fault_n_s),
        .cnt_i        (cnt),
        .cnt_clr_o    (cnt_clr),
        .slot_rst_n_o (slot_rst_n_o),
        .bus_en_o     (bus_en_o),
        .pwr_en_o     (pwr_en_o),
        .status_o     (status_o)
    );

endmodule

// File: rtl/slot_pwr_seq_chk.sv
`timescale 1ns/1ps
// Property checker for the slot sequencer, attached by bind. It watches only
// the top-level outputs and keeps its own run-length counter for the
// enable-low pulse check.
module slot_pwr_seq_chk #(
    parameter int PULSE_MIN_CYC = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       slot_rst_n_o,
    input logic       bus_en_o,
    input logic       pwr_en_o,
    input logic [2:0] status_o
);

    int   low_run;
    logic after_flt;

    // Length of the current enable-low run, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_en_o)         low_run <= 0;
        else if (low_run < PULSE_MIN_CYC) low_run <= low_run + 1;
    end

    // Remember that a fault shutdown preceded the next enable rise.
    always_ff @(posedge clk) begin
        if (!rst_n)             after_flt <= 1'b0;
        else if (status_o == 3'd4) after_flt <= 1'b1;
        else if (pwr_en_o)      after_flt <= 1'b0;
    end

    a_r3_power_on_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_o) |-> (!slot_rst_n_o && !bus_en_o));

    a_r11_release_needs_path: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rst_n_o |-> (bus_en_o && pwr_en_o));

    a_r6_connect_before_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_rst_n_o) |-> $past(bus_en_o));

    a_r7_fault_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 3'd4) |-> (!pwr_en_o && !bus_en_o && !slot_rst_n_o));

    a_r8_min_low_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_en_o) && after_flt) |-> (low_run >= PULSE_MIN_CYC));

    a_r10_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        status_o <= 3'd4);

endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(
    .PULSE_MIN_CYC (PULSE_MIN_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_rst_n_o (slot_rst_n_o),
    .bus_en_o     (bus_en_o),
    .pwr_en_o     (pwr_en_o),
    .status_o     (status_o)
);

// File: tb/slot_pwr_seq_bench.sv
`timescale 1ns/1ps
// Bench: drives slot scenarios and compares every cycle against a
// behavioural model with a two-deep input history queue.
module slot_pwr_seq_bench;

    localparam int PRES_W = 2;
    localparam int PG_MAX = 64;
    localparam int RST_TO = 20;
    localparam int PULSE  = 8;
    localparam int BLANK  = 4;
    localparam logic [PRES_W+2:0] IN_RST = {1'b1, 1'b0, 1'b0, {PRES_W{1'b1}}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PRES_W-1:0] sense = '1;
    logic              op_req = 1'b0, pgood = 1'b0, fault_n = 1'b1;
    logic              rst_o, bus_o, pwr_o;
    logic [2:0]        stat_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    slot_pwr_seq #(
        .PRES_W (PRES_W), .PG_MAX_CYC (PG_MAX), .RST_TO_CYC (RST_TO),
        .PULSE_MIN_CYC (PULSE), .FLT_BLANK_CYC (BLANK), .SYNC_STAGES (2)
    ) u_slot_pwr_seq (
        .clk (clk), .rst_n (rst_n), .card_sense_i (sense), .op_insert_i (op_req),
        .pgood_i (pgood), .fault_n_i (fault_n), .slot_rst_n_o (rst_o),
        .bus_en_o (bus_o), .pwr_en_o (pwr_o), .status_o (stat_o)
    );

    // ---------------- reference model ----------------
    // Phases: 0 idle, 1 powering, 2 waiting, 3 connect, 4 active, 5 fault.
    int                m_ph = 0;
    int                m_cnt = 0;
    logic [PRES_W+2:0] hist[$];

    always @(posedge clk) begin
        logic [PRES_W+2:0] seen;
        bit occ, flt, pg;
        int nx;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0;
            hist = {IN_RST, IN_RST};
        end else begin
            seen = hist[0];
            void'(hist.pop_front());
            hist.push_back({fault_n, pgood, op_req, sense});
            occ = (seen[PRES_W-1:0] != '1) || seen[PRES_W];
            pg  = seen[PRES_W+1];
            flt = !seen[PRES_W+2];
            nx  = m_ph;
            case (m_ph)
                0: if (occ) nx = 1;
                1: if (!occ) nx = 0; else if (flt && m_cnt >= BLANK) nx = 5;
                   else if (pg) nx = 2; else if (m_cnt >= PG_MAX-1) nx = 5;
                2: if (!occ) nx = 0; else if (flt) nx = 5; else if (m_cnt >= RST_TO-1) nx = 3;
                3: if (!occ) nx = 0; else if (flt) nx = 5; else nx = 4;
                4: if (!occ) nx = 0; else if (flt) nx = 5;
                default: if (m_cnt >= PULSE-1) nx = 0;
            endcase
            if (nx != m_ph) m_cnt = 0; else m_cnt++;
            m_ph = nx;
        end
    end

    function automatic int exp_stat(int ph);
        case (ph)
            0: return 0;
            1: return 1;
            2, 3: return 2;
            4: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3",  "cycle pwr_en",     int'(pwr_o), int'(m_ph >= 1 && m_ph <= 4));
            chk("R6",  "cycle bus_en",     int'(bus_o), int'(m_ph == 3 || m_ph == 4));
            chk("R11", "cycle slot_rst_n", int'(rst_o), int'(m_ph == 4));
            chk("R10", "cycle status",     int'(stat_o), exp_stat(m_ph));
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic outs(string tag, int r, int b, int p, int s);
        chk(tag, "slot_rst_n", int'(rst_o), r);
        chk(tag, "bus_en",     int'(bus_o), b);
        chk(tag, "pwr_en",     int'(pwr_o), p);
        chk(tag, "status",     int'(stat_o), s);
    endtask

    initial begin
        tick(4);
        outs("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        tick(3);
        outs("R1", 0, 0, 0, 0);

        // Card inserted via sense bits: full bring-up.
        sense = 2'b10;
        tick(2);
        chk("R2", "pwr_en before sync latency", int'(pwr_o), 0);
        tick(1);
        outs("R2", 0, 0, 1, 1);
        outs("R3", 0, 0, 1, 1);
        pgood = 1'b1;
        tick(2 + RST_TO);
        outs("R5", 0, 0, 1, 2);
        tick(1);
        outs("R6", 0, 1, 1, 2);
        tick(1);
        outs("R6", 1, 1, 1, 3);
        outs("R11", 1, 1, 1, 3);

        // Fault while active, then enable-cycle recovery with restart.
        fault_n = 1'b0;
        tick(3);
        outs("R7", 0, 0, 0, 4);
        fault_n = 1'b1;
        pgood = 1'b0;
        tick(PULSE - 1);
        outs("R8", 0, 0, 0, 4);
        tick(1);
        outs("R8", 0, 0, 0, 0);
        tick(1);
        outs("R8", 0, 0, 1, 1);
        pgood = 1'b1;
        tick(4 + RST_TO);
        outs("R6", 1, 1, 1, 3);

        // Removal while active.
        sense = 2'b11;
        tick(2);
        chk("R9", "status before removal seen", int'(stat_o), 3);
        tick(1);
        outs("R9", 0, 0, 0, 0);
        pgood = 1'b0;
        tick(5);

        // Operator request with empty slot; short fault glitch is blanked; no power-good.
        op_req = 1'b1;
        tick(3);
        outs("R2", 0, 0, 1, 1);
        fault_n = 1'b0;
        tick(1);
        fault_n = 1'b1;
        tick(4);
        outs("R7", 0, 0, 1, 1);
        tick(PG_MAX - 6);
        outs("R4", 0, 0, 1, 1);
        tick(1);
        outs("R4", 0, 0, 0, 4);
        op_req = 1'b0;
        tick(PULSE);
        outs("R8", 0, 0, 0, 0);
        tick(3);
        outs("R8", 0, 0, 0, 0);

        // Fault during powering after the blanking window.
        op_req = 1'b1;
        tick(3);
        outs("R2", 0, 0, 1, 1);
        tick(5);
        fault_n = 1'b0;
        tick(3);
        outs("R7", 0, 0, 0, 4);
        fault_n = 1'b1;
        op_req = 1'b0;
        tick(PULSE + 3);
        outs("R8", 0, 0, 0, 0);

        // Fault while waiting for the reset time-out.
        sense = 2'b01;
        tick(3);
        pgood = 1'b1;
        tick(3);
        outs("R5", 0, 0, 1, 2);
        fault_n = 1'b0;
        tick(3);
        outs("R7", 0, 0, 0, 4);
        fault_n = 1'b1;
        pgood = 1'b0;
        sense = 2'b11;
        tick(PULSE + 4);
        outs("R9", 0, 0, 0, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule